// File: doc/BRIEF.md
# Loop Counter and Branch Unit

This unit produces the next program counter for a small coprocessor whose program memory is addressed in 32-bit words. On each issued instruction it takes the decoded branch fields, the current word PC, the value of register R0 and the two flags left by the last ALU operation. From these it returns the next PC, a flag that says whether control flow was redirected, and the fetch-latency class of the instruction that follows.

Four kinds of branch are supported. An absolute jump takes its target from a register, in words, or from a 13-bit byte immediate. It can be unconditional or gated by the ALU zero or overflow flag. A relative branch compares R0 with a threshold. A second relative branch compares a private 8-bit loop counter with a threshold, and the unit also runs the three instructions that clear, raise and lower that counter. Relative displacements are given in bytes and are turned into word steps inside the unit. Conditions the hardware lacks are built by the assembler from the native ones.

The next-PC, taken and fetch-class outputs are combinational in the issued fields. The loop counter is a register that changes at the clock edge that ends a counter instruction. The current count is on an output port.

Top module: `loop_branch_unit`

## Requirements
- R1: After a synchronous reset the loop counter reads 0.
- R2: A valid counter-clear operation (kind 5) makes the counter 0 at the next clock edge.
- R3: A valid counter-raise (kind 6) or counter-lower (kind 7) adds or subtracts the 8-bit amount at the next clock edge, modulo 256.
- R4: A register absolute jump (kind 1) that is taken goes to the low 11 bits of the register operand, taken as a word address.
- R5: An immediate absolute jump (kind 2) that is taken goes to the 13-bit byte address divided by 4.
- R6: For absolute jumps, condition code 0 always jumps, 1 jumps only when the ALU zero flag is set, and 2 jumps only when the ALU overflow flag is set.
- R7: An R0 branch (kind 3) with code 0 is taken when R0 < threshold, and with code 1 when R0 >= threshold, both compared unsigned.
- R8: A loop-counter branch (kind 4) with code 0 is taken when count < threshold, with code 1 when count >= threshold, and with code 2 when count <= threshold, all compared unsigned.
- R9: A taken relative branch goes to PC plus the sign-extended byte displacement divided by 4, wrapped modulo 2048.
- R10: When nothing is taken, the next PC is PC+1 modulo 2048. This includes the case where no operation is valid.
- R11: The short fetch class (1) is reported after any branch kind, taken or not, and after a valid non-branch operation (kind 0) flagged as ALU. Every other case reports the long class (0).
- R12: Condition code 3 on any branch kind, and code 2 on an R0 branch, is never taken. Counter operations and idle cycles never redirect, and an idle cycle leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction is issued this cycle |
| op_kind | input | 3 | Operation kind: 0 other, 1 reg jump, 2 imm jump, 3 R0 branch, 4 counter branch, 5 clear, 6 raise, 7 lower |
| op_cond | input | 2 | Condition code, meaning depends on kind |
| op_alu | input | 1 | Kind-0 operation is an ALU instruction |
| op_reg_tgt | input | 16 | Register operand holding a word target |
| op_imm_addr | input | 13 | Immediate byte target |
| op_disp | input | 10 | Signed byte displacement |
| op_thresh | input | 16 | Comparison threshold |
| op_amount | input | 8 | Counter step amount |
| r0_val | input | 16 | Current value of R0 |
| alu_zero | input | 1 | Last ALU result was zero |
| alu_ovf | input | 1 | Last ALU operation overflowed |
| pc_cur | input | 11 | Word address of the current instruction |
| pc_next | output | 11 | Word address of the next instruction |
| taken | output | 1 | Control flow redirected |
| fetch_short | output | 1 | Next fetch uses the short latency |
| stage_count | output | 8 | Current loop counter |

## Verification
The assertions assume that op_kind, op_cond and op_amount are stable and defined whenever op_valid is high. They also assume that reset is held for at least one edge before any operation is issued. The bench meets this by changing every input only on the falling clock edge and by driving all inputs to known values at time zero. It also keeps op_valid low during reset and between scenarios, so the counter checks see only the operations issued on purpose.

// File: rtl/bnc_pkg.sv
package bnc_pkg;

    typedef enum logic [2:0] {
        OP_OTHER    = 3'd0,
        OP_JABS_REG = 3'd1,
        OP_JABS_IMM = 3'd2,
        OP_JREL_R0  = 3'd3,
        OP_JREL_STG = 3'd4,
        OP_STG_CLR  = 3'd5,
        OP_STG_INC  = 3'd6,
        OP_STG_DEC  = 3'd7
    } bnc_op_e;

    // condition codes for absolute jumps
    localparam logic [1:0] CA_ALWAYS = 2'd0;
    localparam logic [1:0] CA_ZERO   = 2'd1;
    localparam logic [1:0] CA_OVF    = 2'd2;

    // condition codes for relative branches
    localparam logic [1:0] CR_LT = 2'd0;
    localparam logic [1:0] CR_GE = 2'd1;
    localparam logic [1:0] CR_LE = 2'd2;

    typedef struct packed {
        logic lt;
        logic eq;
    } bnc_cmp_t;

    typedef enum logic {
        FETCH_LONG  = 1'b0,
        FETCH_SHORT = 1'b1
    } bnc_fetch_e;

    function automatic logic is_branch(bnc_op_e k);
        return (k == OP_JABS_REG) || (k == OP_JABS_IMM) ||
               (k == OP_JREL_R0)  || (k == OP_JREL_STG);
    endfunction

    function automatic logic is_stage_op(bnc_op_e k);
        return (k == OP_STG_CLR) || (k == OP_STG_INC) || (k == OP_STG_DEC);
    endfunction

    function automatic bnc_fetch_e fetch_class(logic valid, bnc_op_e k, logic alu);
        if (valid && (is_branch(k) || (k == OP_OTHER && alu)))
            return FETCH_SHORT;
        return FETCH_LONG;
    endfunction

endpackage

// File: rtl/bnc_cond_eval.sv
module bnc_cond_eval
    import bnc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STG_W  = 8
) (
    input  bnc_op_e             kind,
    input  logic [1:0]          cond,
    input  logic [DATA_W-1:0]   thresh,
    input  logic [DATA_W-1:0]   r0_val,
    input  logic [STG_W-1:0]    stage,
    input  logic                alu_zero,
    input  logic                alu_ovf,
    output logic                cond_true
);
    localparam int unsigned CMP_W = (DATA_W > STG_W) ? DATA_W : STG_W;

    logic [CMP_W-1:0] r0_ext, stg_ext, thr_ext;
    bnc_cmp_t         r0_cmp, stg_cmp;

    assign r0_ext  = CMP_W'(r0_val);
    assign stg_ext = CMP_W'(stage);
    assign thr_ext = CMP_W'(thresh);

    always_comb begin
        r0_cmp.lt  = r0_ext < thr_ext;
        r0_cmp.eq  = r0_ext == thr_ext;
        stg_cmp.lt = stg_ext < thr_ext;
        stg_cmp.eq = stg_ext == thr_ext;
    end

    always_comb begin
        cond_true = 1'b0;
        unique case (kind)
            OP_JABS_REG, OP_JABS_IMM: begin
                case (cond)
                    CA_ALWAYS: cond_true = 1'b1;
                    CA_ZERO:   cond_true = alu_zero;
                    CA_OVF:    cond_true = alu_ovf;
                    default:   cond_true = 1'b0;
                endcase
            end
            OP_JREL_R0: begin
                case (cond)
                    CR_LT:   cond_true = r0_cmp.lt;
                    CR_GE:   cond_true = !r0_cmp.lt;
                    default: cond_true = 1'b0;
                endcase
            end
            OP_JREL_STG: begin
                case (cond)
                    CR_LT:   cond_true = stg_cmp.lt;
                    CR_GE:   cond_true = !stg_cmp.lt;
                    CR_LE:   cond_true = stg_cmp.lt || stg_cmp.eq;
                    default: cond_true = 1'b0;
                endcase
            end
            default: cond_true = 1'b0;
        endcase
    end

    // R12: reserved code 3 never evaluates true
    always_comb begin
        if (cond == 2'd3)
            a_r12_reserved_cond: assert (!cond_true);
    end

endmodule

// File: rtl/bnc_target_calc.sv
module bnc_target_calc
    import bnc_pkg::*;
#(
    parameter int unsigned PC_W   = 11,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned IMM_W  = 13,
    parameter int unsigned DISP_W = 10
) (
    input  bnc_op_e             kind,
    input  logic [DATA_W-1:0]   reg_tgt,
    input  logic [IMM_W-1:0]    imm_addr,
    input  logic [DISP_W-1:0]   disp,
    input  logic [PC_W-1:0]     pc_cur,
    output logic [PC_W-1:0]     target
);
    localparam int unsigned IMM_WORD_W  = IMM_W - 2;
    localparam int unsigned DISP_WORD_W = DISP_W - 2;

    logic [PC_W-1:0] reg_word, imm_word, rel_step;
    logic [1:0]      unused_low_bits;

    assign unused_low_bits = imm_addr[1:0] ^ disp[1:0];

    generate
        if (DATA_W > PC_W) begin : g_reg_trunc
            logic [DATA_W-PC_W-1:0] unused_tgt_hi;
            assign unused_tgt_hi = reg_tgt[DATA_W-1:PC_W];
            assign reg_word      = reg_tgt[PC_W-1:0];
        end else begin : g_reg_ext
            assign reg_word = PC_W'(reg_tgt);
        end

        if (IMM_WORD_W >= PC_W) begin : g_imm_trunc
            assign imm_word = imm_addr[PC_W+1:2];
        end else begin : g_imm_ext
            assign imm_word = PC_W'(imm_addr[IMM_W-1:2]);
        end

        // byte displacement / 4, sign preserved
        if (DISP_WORD_W >= PC_W) begin : g_disp_trunc
            assign rel_step = disp[PC_W+1:2];
        end else begin : g_disp_ext
            assign rel_step = {{(PC_W-DISP_WORD_W){disp[DISP_W-1]}}, disp[DISP_W-1:2]};
        end
    endgenerate

    always_comb begin
        unique case (kind)
            OP_JABS_REG:             target = reg_word;
            OP_JABS_IMM:             target = imm_word;
            OP_JREL_R0, OP_JREL_STG: target = pc_cur + rel_step;
            default:                 target = pc_cur + PC_W'(1);
        endcase
    end

endmodule

// File: rtl/bnc_stage_counter.sv
module bnc_stage_counter
    import bnc_pkg::*;
#(
    parameter int unsigned STG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  bnc_op_e           kind,
    input  logic [STG_W-1:0]  amount,
    output logic [STG_W-1:0]  count
);
    logic [STG_W-1:0] count_d;

    always_comb begin
        count_d = count;
        if (op_valid) begin
            case (kind)
                OP_STG_CLR: count_d = '0;
                OP_STG_INC: count_d = count + amount;
                OP_STG_DEC: count_d = count - amount;
                default:    count_d = count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_d;
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (count == '0));

    a_r2_clear: assert property (@(posedge clk) disable iff (rst)
        (op_valid && kind == OP_STG_CLR) |=> (count == '0));

    a_r3_raise: assert property (@(posedge clk) disable iff (rst)
        (op_valid && kind == OP_STG_INC) |=>
            (count == STG_W'($past(count) + $past(amount))));

    a_r3_lower: assert property (@(posedge clk) disable iff (rst)
        (op_valid && kind == OP_STG_DEC) |=>
            (count == STG_W'($past(count) - $past(amount))));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!op_valid) |=> $stable(count));

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import bnc_pkg::*;
#(
    parameter int unsigned PC_W   = 11,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STG_W  = 8,
    parameter int unsigned IMM_W  = 13,
    parameter int unsigned DISP_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [1:0]        op_cond,
    input  logic              op_alu,
    input  logic [DATA_W-1:0] op_reg_tgt,
    input  logic [IMM_W-1:0]  op_imm_addr,
    input  logic [DISP_W-1:0] op_disp,
    input  logic [DATA_W-1:0] op_thresh,
    input  logic [STG_W-1:0]  op_amount,
    input  logic [DATA_W-1:0] r0_val,
    input  logic              alu_zero,
    input  logic              alu_ovf,
    input  logic [PC_W-1:0]   pc_cur,
    output logic [PC_W-1:0]   pc_next,
    output logic              taken,
    output logic              fetch_short,
    output logic [STG_W-1:0]  stage_count
);
    bnc_op_e          kind;
    logic             cond_true;
    logic [PC_W-1:0]  target;
    logic [PC_W-1:0]  pc_seq;
    bnc_fetch_e       fclass;

    assign kind = bnc_op_e'(op_kind);

    bnc_stage_counter #(.STG_W(STG_W)) i_counter (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .kind     (kind),
        .amount   (op_amount),
        .count    (stage_count)
    );

    bnc_cond_eval #(.DATA_W(DATA_W), .STG_W(STG_W)) i_cond (
        .kind      (kind),
        .cond      (op_cond),
        .thresh    (op_thresh),
        .r0_val    (r0_val),
        .stage     (stage_count),
        .alu_zero  (alu_zero),
        .alu_ovf   (alu_ovf),
        .cond_true (cond_true)
    );

    bnc_target_calc #(
        .PC_W(PC_W), .DATA_W(DATA_W), .IMM_W(IMM_W), .DISP_W(DISP_W)
    ) i_target (
        .kind     (kind),
        .reg_tgt  (op_reg_tgt),
        .imm_addr (op_imm_addr),
        .disp     (op_disp),
        .pc_cur   (pc_cur),
        .target   (target)
    );

    assign pc_seq      = pc_cur + PC_W'(1);
    assign taken       = op_valid && is_branch(kind) && cond_true;
    assign pc_next     = taken ? target : pc_seq;
    assign fclass      = fetch_class(op_valid, kind, op_alu);
    assign fetch_short = (fclass == FETCH_SHORT);

    a_r11_taken_short: assert property (@(posedge clk) disable iff (rst)
        taken |-> fetch_short);

    a_r12_stage_no_redirect: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_stage_op(kind)) |-> !taken);

    a_r12_idle_no_redirect: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (!taken && !fetch_short));

    a_r6_unconditional: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (kind == OP_JABS_IMM || kind == OP_JABS_REG) &&
         op_cond == CA_ALWAYS) |-> taken);

endmodule

// File: tb/test_loop_branch_unit.sv
module test_loop_branch_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [1:0]  op_cond = '0;
    logic        op_alu = 1'b0;
    logic [15:0] op_reg_tgt = '0;
    logic [12:0] op_imm_addr = '0;
    logic [9:0]  op_disp = '0;
    logic [15:0] op_thresh = '0;
    logic [7:0]  op_amount = '0;
    logic [15:0] r0_val = '0;
    logic        alu_zero = 1'b0;
    logic        alu_ovf = 1'b0;
    logic [10:0] pc_cur = '0;
    logic [10:0] pc_next;
    logic        taken;
    logic        fetch_short;
    logic [7:0]  stage_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_branch_unit i_loop_branch_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_cond(op_cond), .op_alu(op_alu), .op_reg_tgt(op_reg_tgt),
        .op_imm_addr(op_imm_addr), .op_disp(op_disp), .op_thresh(op_thresh),
        .op_amount(op_amount), .r0_val(r0_val), .alu_zero(alu_zero),
        .alu_ovf(alu_ovf), .pc_cur(pc_cur), .pc_next(pc_next), .taken(taken),
        .fetch_short(fetch_short), .stage_count(stage_count)
    );

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // drive a branch-style op just after a falling edge, sample 1 time unit later
    task automatic issue(int kind, int cond, int pc);
        @(negedge clk);
        op_valid = 1'b1;
        op_kind  = 3'(kind);
        op_cond  = 2'(cond);
        pc_cur   = 11'(pc);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 1'b0;
        op_kind  = '0;
        #1;
    endtask

    // counter op; result visible after the following rising edge
    task automatic count_op(int kind, int amt, int exp, string req);
        issue(kind, 0, 100);
        op_amount = 8'(amt);
        #1;
        check({req, " no redirect"}, int'(taken), 0);
        check({req, " next pc"}, int'(pc_next), 101);
        idle();
        check(req, int'(stage_count), exp);
    endtask

    task automatic t_reset();
        check("R1 counter after reset", int'(stage_count), 0);
        check("R10 idle next pc", int'(pc_next), 1);
        check("R12 idle not taken", int'(taken), 0);
        check("R11 idle long fetch", int'(fetch_short), 0);
    endtask

    task automatic t_counter();
        count_op(6, 5, 5, "R3 raise");
        count_op(6, 8'hFE, 3, "R3 raise wrap");
        count_op(7, 4, 8'hFF, "R3 lower wrap");
        count_op(5, 0, 0, "R2 clear");
        count_op(6, 16, 16, "R3 raise to 16");
        repeat (3) @(negedge clk);
        #1;
        check("R12 idle holds counter", int'(stage_count), 16);
    endtask

    task automatic t_absolute();
        op_reg_tgt = 16'h1234;
        issue(1, 0, 7);
        check("R4 reg jump taken", int'(taken), 1);
        check("R4 reg jump target", int'(pc_next), 11'h234);
        op_imm_addr = 13'h120;
        issue(2, 0, 7);
        check("R5 imm jump target", int'(pc_next), 13'h120 >> 2);
        alu_zero = 1'b0; alu_ovf = 1'b1;
        issue(2, 1, 7);
        check("R6 zero cond off", int'(taken), 0);
        check("R10 zero cond off pc", int'(pc_next), 8);
        check("R11 untaken branch short", int'(fetch_short), 1);
        alu_zero = 1'b1; alu_ovf = 1'b0;
        issue(2, 1, 7);
        check("R6 zero cond on", int'(pc_next), 11'h48);
        issue(1, 2, 7);
        check("R6 ovf cond off", int'(taken), 0);
        alu_ovf = 1'b1;
        issue(1, 2, 7);
        check("R6 ovf cond on", int'(pc_next), 11'h234);
        issue(1, 3, 7);
        check("R12 abs code 3", int'(taken), 0);
        idle();
    endtask

    task automatic t_r0_branch();
        op_thresh = 16'd20;
        op_disp   = 10'd16;
        r0_val    = 16'd19;
        issue(3, 0, 50);
        check("R7 lt taken", int'(pc_next), 54);
        issue(3, 1, 50);
        check("R7 ge not taken", int'(pc_next), 51);
        r0_val = 16'd20;
        issue(3, 0, 50);
        check("R7 lt at equal", int'(taken), 0);
        issue(3, 1, 50);
        check("R7 ge at equal", int'(taken), 1);
        r0_val = 16'hFFFF; op_thresh = 16'd1;
        issue(3, 1, 50);
        check("R7 unsigned ge", int'(taken), 1);
        issue(3, 2, 50);
        check("R12 r0 code 2", int'(taken), 0);
        issue(3, 3, 50);
        check("R12 r0 code 3", int'(taken), 0);
        idle();
    endtask

    task automatic t_displacement();
        op_thresh = 16'd0; r0_val = 16'd0;
        op_disp = 10'h3F8;                // -8 bytes
        issue(3, 1, 1);
        check("R9 negative wrap", int'(pc_next), 2047);
        op_disp = 10'd16;
        issue(3, 1, 2040);
        check("R9 forward", int'(pc_next), 2044);
        issue(3, 1, 2046);
        check("R9 forward wrap", int'(pc_next), 2);
        op_disp = 10'h200;                // -512 bytes
        issue(3, 1, 200);
        check("R9 most negative", int'(pc_next), 72);
        issue(0, 0, 2047);
        check("R10 sequential wrap", int'(pc_next), 0);
        idle();
    endtask

    task automatic t_stage_branch();
        // counter holds 16 here
        op_disp = 10'd8;
        op_thresh = 16'd16;
        issue(4, 0, 10);
        check("R8 lt at equal", int'(taken), 0);
        issue(4, 2, 10);
        check("R8 le at equal", int'(pc_next), 12);
        issue(4, 1, 10);
        check("R8 ge at equal", int'(taken), 1);
        op_thresh = 16'd17;
        issue(4, 0, 10);
        check("R8 lt below", int'(taken), 1);
        issue(4, 1, 10);
        check("R8 ge below", int'(pc_next), 11);
        op_thresh = 16'd15;
        issue(4, 2, 10);
        check("R8 le above", int'(taken), 0);
        issue(4, 3, 10);
        check("R12 stage code 3", int'(taken), 0);
        idle();
    endtask

    task automatic t_fetch();
        op_alu = 1'b1;
        issue(0, 0, 3);
        check("R11 alu short", int'(fetch_short), 1);
        op_alu = 1'b0;
        issue(0, 0, 3);
        check("R11 other long", int'(fetch_short), 0);
        op_amount = 8'd0;
        issue(6, 0, 3);
        check("R11 counter op long", int'(fetch_short), 0);
        op_alu = 1'b1;
        issue(5, 0, 3);
        check("R11 clear long even if alu", int'(fetch_short), 0);
        idle();
        check("R2 clear from fetch test", int'(stage_count), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_counter();
        t_absolute();
        t_r0_branch();
        t_displacement();
        t_stage_branch();
        t_fetch();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule